// File: doc/BRIEF.md
# Streaming Dot-Product Engine

This block computes the inner product of two integer vectors that arrive as a stream, one operand pair per clock. Each pair enters a multiplier pipeline of fixed depth. The products then enter an accumulator ring whose last stage feeds back into its own adder. Because the ring holds one running sum per stage, a product is added to the sum built from the terms one ring length earlier. With the default depth of four, terms 1, 5, 9, ... share one sum, terms 2, 6, 10, ... share the next, and so on.

Software, or an upstream engine, pulses `start` while the unit is idle. This wipes every pipeline and ring register. It then pushes pairs over a valid/ready input and marks the final pair with `in_last`. Once that pair is accepted, the unit closes its input and lets the multiplier drain. It then adds the ring's partial sums into one result and offers that result on a valid/ready output.

Back-pressure rules: `in_ready` is high only while a vector is being taken in, and a pair moves on any rising edge where `in_valid` and `in_ready` are both high. A cycle with `in_valid` low is a bubble and adds nothing. The result is offered with `out_valid` and stays unchanged until a clock edge where `out_ready` is also high. Only after that edge can a new vector be started.

Top module: `dot_stream_unit`

## Requirements
- R1: After reset, `in_ready` and `out_valid` are 0 and `out_sum` is 0.
- R2: A `start` pulse while idle raises `in_ready` from the next cycle on. It also zeroes every multiplier and accumulator register, so no data from an earlier vector reaches the new result.
- R3: While `in_ready` is high, one pair is accepted on each edge with `in_valid` high. Edges with `in_valid` low leave the result unaffected.
- R4: `out_sum` equals the sum of the products of all accepted pairs, up to and including the one marked `in_last`. Operands are two's-complement signed values `IN_W` bits wide. The sum is signed, `ACC_W` bits wide, and wraps modulo 2^ACC_W.
- R5: When the pair with `in_last` is accepted on edge E, `out_valid` first reads 1 after edge E + MUL_STAGES + 1, which is 5 cycles with the defaults.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_sum` holds its value. After an edge with both high, `out_valid` is 0 and the unit is idle.
- R7: `in_ready` is 0 from the edge that accepts the last pair until the result has been taken. `start` has no effect unless the unit is idle.
- R8: Vectors of any length from 1 up, including lengths that are not a multiple of the ring depth, give the correct sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a vector and clears all stages; acted on only while idle |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Unit takes a pair on this edge if `in_valid` is high |
| in_a | input | IN_W | First operand, signed |
| in_b | input | IN_W | Second operand, signed |
| in_last | input | 1 | Marks the final pair of the vector |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_sum | output | ACC_W | Inner product, signed |

## Verification
Vectors run back to back, so the ring still holds the previous vector's partial sums when the next one starts. A design that skipped the clear would return the old total added to the new one. Lengths 1, 3, 5 and 7 leave some ring lanes unused, and a wrong drain count would either drop the final product or report a sum taken before it arrived; the bench also measures the exact latency. Bubbles inside a vector, full-scale negative operands and an output stall of several cycles, with `start` pulsed during intake and while the result waits, catch an engine that counts idle cycles as terms, loses the sign, lets the result change under stall, or restarts in the middle of a vector.

// File: rtl/dsu_pkg.sv
package dsu_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FEED  = 2'd1,
    ST_FLUSH = 2'd2,
    ST_DONE  = 2'd3
  } dsu_state_e;
endpackage

// File: rtl/dsu_mul_pipe.sv
module dsu_mul_pipe #(
  parameter int IN_W   = 16,
  parameter int ACC_W  = 40,
  parameter int STAGES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    load,
  input  logic signed [IN_W-1:0]  a,
  input  logic signed [IN_W-1:0]  b,
  output logic signed [ACC_W-1:0] prod_out
);
  logic signed [ACC_W-1:0] stg [STAGES];
  logic signed [ACC_W-1:0] a_x, b_x;

  assign a_x = ACC_W'(a);
  assign b_x = ACC_W'(b);

  // Stage 0 forms the product; a bubble loads zero so the ring adds nothing.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     stg[0] <= '0;
    else if (clr)   stg[0] <= '0;
    else if (load)  stg[0] <= a_x * b_x;
    else            stg[0] <= '0;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_delay
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   stg[g] <= '0;
      else if (clr) stg[g] <= '0;
      else          stg[g] <= stg[g-1];
    end
  end

  assign prod_out = stg[STAGES-1];

  // R7: intake can never coincide with the clearing pulse.
  a_r7_no_load_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !(clr && load));
endmodule

// File: rtl/dsu_acc_ring.sv
module dsu_acc_ring #(
  parameter int ACC_W = 40,
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic signed [ACC_W-1:0] prod_in,
  output logic signed [ACC_W-1:0] total
);
  logic signed [ACC_W-1:0] stg [LANES];

  // Head stage adds the incoming product to the sum leaving the tail.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stg[0] <= '0;
    else if (clr) stg[0] <= '0;
    else          stg[0] <= stg[LANES-1] + prod_in;
  end

  for (genvar g = 1; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   stg[g] <= '0;
      else if (clr) stg[g] <= '0;
      else          stg[g] <= stg[g-1];
    end
  end

  // Merge of the interleaved partial sums.
  always_comb begin
    total = '0;
    for (int i = 0; i < LANES; i++) total += stg[i];
  end

  // R2: a clear leaves nothing in the ring.
  a_r2_ring_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (total == '0));
  // R4: rotating with a zero product never changes the merged total.
  a_r4_sum_invariant: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && prod_in == '0) |=> $stable(total));
endmodule

// File: rtl/dsu_ctrl.sv
module dsu_ctrl
  import dsu_pkg::*;
#(
  parameter int FLUSH_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_valid,
  input  logic in_last,
  input  logic out_ready,
  output logic in_ready,
  output logic fire,
  output logic clr,
  output logic cap,
  output logic out_valid
);
  localparam int CNT_W = $clog2(FLUSH_CYC + 1);

  dsu_state_e       st;
  logic [CNT_W-1:0] cnt;

  assign in_ready  = (st == ST_FEED);
  assign fire      = in_ready && in_valid;
  assign clr       = (st == ST_IDLE) && start;
  assign cap       = (st == ST_FLUSH) && (cnt == CNT_W'(FLUSH_CYC));
  assign out_valid = (st == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      unique case (st)
        ST_IDLE:  if (start) st <= ST_FEED;
        ST_FEED:  if (fire && in_last) begin
                    st  <= ST_FLUSH;
                    cnt <= '0;
                  end
        ST_FLUSH: if (cap) st <= ST_DONE;
                  else     cnt <= cnt + 1'b1;
        ST_DONE:  if (out_ready) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  // R7: intake is closed whenever a result is on offer.
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  // R6: a taken result is withdrawn on the following cycle.
  a_r6_single_take: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);
endmodule

// File: rtl/dot_stream_unit.sv
module dot_stream_unit #(
  parameter int IN_W       = 16,
  parameter int ACC_W      = 40,
  parameter int MUL_STAGES = 4,
  parameter int ADD_LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [IN_W-1:0]  in_a,
  input  logic signed [IN_W-1:0]  in_b,
  input  logic                    in_last,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [ACC_W-1:0] out_sum
);
  // Last product leaves the multiplier and enters the ring MUL_STAGES
  // edges after its acceptance; the merge is captured one edge later.
  localparam int FLUSH_CYC = MUL_STAGES;

  logic                    fire, clr, cap;
  logic signed [ACC_W-1:0] prod, total;

  dsu_ctrl #(.FLUSH_CYC(FLUSH_CYC)) u_ctrl (
    .clk, .rst_n, .start, .in_valid, .in_last, .out_ready,
    .in_ready, .fire, .clr, .cap, .out_valid
  );

  dsu_mul_pipe #(.IN_W(IN_W), .ACC_W(ACC_W), .STAGES(MUL_STAGES)) u_mul (
    .clk, .rst_n, .clr, .load(fire), .a(in_a), .b(in_b), .prod_out(prod)
  );

  dsu_acc_ring #(.ACC_W(ACC_W), .LANES(ADD_LANES)) u_ring (
    .clk, .rst_n, .clr, .prod_in(prod), .total
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   out_sum <= '0;
    else if (cap) out_sum <= total;
  end

  // R6: a stalled result neither vanishes nor changes.
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_sum)));
endmodule

// File: tb/sim_dot_stream_unit.sv
module sim_dot_stream_unit;
  localparam int IN_W = 16;
  localparam int ACC_W = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic in_last = 1'b0;
  logic out_ready = 1'b1;
  logic signed [IN_W-1:0] in_a = '0;
  logic signed [IN_W-1:0] in_b = '0;
  logic in_ready, out_valid;
  logic signed [ACC_W-1:0] out_sum;

  int checks = 0;
  int fails = 0;
  logic signed [IN_W-1:0] va [16];
  logic signed [IN_W-1:0] vb [16];

  always #10 clk = ~clk;

  dot_stream_unit u0 (
    .clk, .rst_n, .start, .in_valid, .in_ready, .in_a, .in_b, .in_last,
    .out_valid, .out_ready, .out_sum
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic signed [ACC_W-1:0] ref_sum(input int n);
    logic signed [ACC_W-1:0] acc = '0;
    for (int i = 0; i < n; i++) acc += ACC_W'(va[i]) * ACC_W'(vb[i]);
    return acc;
  endfunction

  task automatic fill(input int n, input int k);
    for (int i = 0; i < n; i++) begin
      va[i] = IN_W'(i * 37 - 90 + k);
      vb[i] = IN_W'(55 - i * 13 + 3 * k);
    end
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Feeds items [from, to); marks the final one as last when asked.
  task automatic feed(input int from, input int to, input bit gaps, input bit mark_last);
    for (int i = from; i < to; i++) begin
      if (gaps && (i % 2 == 1)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_a = va[i];
      in_b = vb[i];
      in_last = mark_last && (i == to - 1);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last = 1'b0;
  endtask

  task automatic wait_result(output int lat);
    lat = 0;
    while (!out_valid && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic t_reset();
    chk(in_ready == 1'b0, "R1", "in_ready after reset", in_ready, 0);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(out_sum == '0, "R1", "out_sum after reset", out_sum, 0);
  endtask

  task automatic t_vector(input string req, input int n, input bit gaps, input int k);
    int lat;
    logic signed [ACC_W-1:0] exp;
    fill(n, k);
    exp = ref_sum(n);
    pulse_start();
    chk(in_ready == 1'b1, "R2", "in_ready after start", in_ready, 1);
    feed(0, n, gaps, 1'b1);
    chk(in_ready == 1'b0, "R7", "in_ready after last", in_ready, 0);
    wait_result(lat);
    chk(lat == 5, "R5", "latency from last", lat, 5);
    chk(out_sum == exp, req, $sformatf("sum n=%0d gaps=%0d", n, gaps), out_sum, exp);
    @(negedge clk);
    chk(out_valid == 1'b0, "R6", "out_valid after take", out_valid, 0);
    chk(in_ready == 1'b0, "R7", "idle after take", in_ready, 0);
  endtask

  task automatic t_extreme();
    int lat;
    logic signed [ACC_W-1:0] exp;
    for (int i = 0; i < 16; i++) begin
      va[i] = (i % 3 == 0) ? -16'sd32768 : 16'sd32767;
      vb[i] = (i % 2 == 0) ? -16'sd32768 : -16'sd1;
    end
    exp = ref_sum(16);
    pulse_start();
    feed(0, 16, 1'b0, 1'b1);
    wait_result(lat);
    chk(out_sum == exp, "R4", "signed full-scale sum", out_sum, exp);
    @(negedge clk);
  endtask

  task automatic t_stall();
    int lat;
    logic signed [ACC_W-1:0] exp;
    fill(6, 7);
    exp = ref_sum(6);
    out_ready = 1'b0;
    pulse_start();
    feed(0, 6, 1'b0, 1'b1);
    wait_result(lat);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(out_valid == 1'b1, "R6", "valid held under stall", out_valid, 1);
      chk(out_sum == exp, "R6", "sum stable under stall", out_sum, exp);
      chk(in_ready == 1'b0, "R7", "intake closed under stall", in_ready, 0);
    end
    // start while a result waits must be ignored
    pulse_start();
    chk(out_valid == 1'b1, "R7", "start ignored while done", out_valid, 1);
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R6", "taken after release", out_valid, 0);
    chk(in_ready == 1'b0, "R7", "no restart from ignored start", in_ready, 0);
    chk(out_sum == exp, "R6", "sum kept after take", out_sum, exp);
  endtask

  task automatic t_start_mid();
    int lat;
    logic signed [ACC_W-1:0] exp;
    fill(9, 3);
    exp = ref_sum(9);
    pulse_start();
    feed(0, 4, 1'b0, 1'b0);
    pulse_start();
    chk(in_ready == 1'b1, "R7", "intake open after mid start", in_ready, 1);
    feed(4, 9, 1'b0, 1'b1);
    wait_result(lat);
    chk(out_sum == exp, "R7", "mid-vector start ignored", out_sum, exp);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_vector("R4", 8, 1'b0, 0);
    t_vector("R2", 8, 1'b0, 11);   // ring held previous sums: clear needed
    t_vector("R8", 1, 1'b0, 5);
    t_vector("R8", 3, 1'b0, 2);
    t_vector("R8", 5, 1'b0, 9);
    t_vector("R8", 7, 1'b0, 4);
    t_vector("R3", 12, 1'b1, 6);
    t_extreme();
    t_stall();
    t_start_mid();
    t_vector("R4", 16, 1'b1, 1);
    finish_run();
  end
endmodule